// File: doc/BRIEF.md
# UART FIFO and Interrupt Controller

This block holds the data buffers and the interrupt logic that sit between a host register interface and a serial transceiver. A transmit queue of bytes is filled by the host and drained by the transmitter. A receive queue of 10-bit words is filled by the receiver and drained by the host. Each receive word carries the data byte in bits 7:0, a parity-error flag in bit 8 and a framing-error flag in bit 9.

When queueing is switched off, each direction behaves as a single holding register. When it is on, each direction holds up to `DEPTH` entries. The transmit fill count is compared with a 4-bit low-water mark and the receive fill count with a 4-bit high-water mark. Live level flags and latched event flags together form a 13-bit status word. That word is masked by a 13-bit enable word and ORed into one interrupt line. Both fill counts are reported in one packed word. The serial engine and the address decoding are not part of this block.

Top module: `uart_fifo_irq`

## Requirements
- R1: After reset both queues are empty, queueing is off, both marks are 0, every enable bit is 0, `fill_level` is 0, `irq_status` is 13'h001 and `irq` is low.
- R2: A write to `fifo_ctrl_wdata` loads the configuration. Bit 0 enables queueing, which gives a capacity of `DEPTH` per direction; when bit 0 is 0 the capacity is 1. Bits 7:4 are the transmit low-water mark and bits 11:8 the receive high-water mark. Bit 1 has no effect.
- R3: The transmit queue is first-in first-out. `eng_tx_valid` is high and `eng_tx_data` shows the oldest byte whenever the queue is not empty, and `eng_tx_req` removes that byte. A host push into a full queue is dropped.
- R4: The receive queue is first-in first-out on the full 10-bit word. `rx_rdata` shows the oldest word, and `rx_rd` removes it when the queue is not empty.
- R5: A control write with bit 2 set empties the transmit queue, and one with bit 3 set empties the receive queue. Each flush leaves the other queue untouched.
- R6: `fill_level` bits 4:0 give the transmit count and bits 12:8 the receive count; bits 7:5 are 0. The live status bits are:
  - bit 0 = transmit count is 0;
  - bit 1 = receive count is not 0;
  - bit 2 = queueing on and transmit count at or below the low-water mark;
  - bit 3 = queueing on and transmit count is 0;
  - bit 4 = queueing on and receive count at or above the high-water mark;
  - bit 5 = queueing on and receive count equals `DEPTH`.
- R7: A received word that arrives while the receive queue is full is dropped, and status bit 7 is set.
- R8: `eng_tx_req` while the transmit queue is empty sets status bit 6.
- R9: Accepting a receive word with bit 8 set sets status bit 8. Accepting one with bit 9 set sets status bit 9.
- R10: `eng_cts_toggle` sets status bit 10, and `eng_break_done` sets status bit 12.
- R11: Status bit 11 is set on the `TMO_CHARS`-th `eng_char_tick` seen since the last receive word arrived, provided the receive queue stayed non-empty. Each new arrival restarts the count.
- R12: Status bits 12:6 stay set until a `irq_clr_wr` write has a 1 in their position. Writing 1 to bits 5:0 has no effect. A set and a clear in the same cycle leave the bit set.
- R13: `irq` equals the OR over all 13 positions of status AND enable. The enable word is loaded by `irq_en_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_ctrl_wr | input | 1 | Control write strobe |
| fifo_ctrl_wdata | input | 12 | Control word: enable, flushes, marks |
| irq_en_wr | input | 1 | Enable word write strobe |
| irq_en_wdata | input | 13 | New enable word |
| irq_clr_wr | input | 1 | Status clear strobe |
| irq_clr_wdata | input | 13 | Write-one-to-clear mask |
| tx_wr | input | 1 | Host push into the transmit queue |
| tx_wdata | input | 8 | Byte to push |
| rx_rd | input | 1 | Host pop from the receive queue |
| rx_rdata | output | 10 | Oldest receive word |
| fill_level | output | 13 | Packed transmit and receive counts |
| irq_status | output | 13 | Status word |
| irq | output | 1 | Interrupt request |
| eng_tx_req | input | 1 | Transmitter takes a byte |
| eng_tx_valid | output | 1 | A byte is available to the transmitter |
| eng_tx_data | output | 8 | Oldest transmit byte |
| eng_rx_valid | input | 1 | Receiver delivers a word |
| eng_rx_word | input | 10 | Received word with error flags |
| eng_cts_toggle | input | 1 | Clear-to-send line changed |
| eng_break_done | input | 1 | Break sequence finished |
| eng_char_tick | input | 1 | One pulse per character time |

## Verification
Some properties are checked on every cycle:
- no queue count ever exceeds its depth;
- a push into a full queue or an overrun word leaves the count unchanged;
- a latched status bit never falls without a clear write;
- underrun and overrun set their bits on the next cycle;
- a zero enable word keeps `irq` low;
- control bit 1 never flushes anything.

Other behaviours are shown only by the bench scenarios:
- the mark comparisons, swept over every threshold and every fill count;
- data ordering through both queues;
- the exact tick on which the receive timeout fires;
- the masking of each interrupt source one at a time.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

    localparam int ST_W        = 13;
    localparam int ST_TXD_MT   = 0;
    localparam int ST_RXD_RDY  = 1;
    localparam int ST_TX_LOW   = 2;
    localparam int ST_TX_MT    = 3;
    localparam int ST_RX_HIGH  = 4;
    localparam int ST_RX_FULL  = 5;
    localparam int ST_TX_UNDER = 6;
    localparam int ST_RX_OVER  = 7;
    localparam int ST_PAR_ERR  = 8;
    localparam int ST_FRM_ERR  = 9;
    localparam int ST_CTS_CHG  = 10;
    localparam int ST_RX_TMO   = 11;
    localparam int ST_BRK_END  = 12;

    // latched (write-one-to-clear) positions are 12:6
    localparam logic [ST_W-1:0] LATCH_MASK = 13'h1FC0;

    localparam int CTL_W       = 12;
    localparam int CTL_ON      = 0;
    localparam int CTL_TXFLUSH = 2;
    localparam int CTL_RXFLUSH = 3;
    localparam int MARK_W      = 4;
    localparam int CTL_TXMARK  = 4;
    localparam int CTL_RXMARK  = 8;

    localparam int RXW_W       = 10;
    localparam int RXW_PAR     = 8;
    localparam int RXW_FRM     = 9;

    typedef struct packed {
        logic              q_on;
        logic [MARK_W-1:0] tx_mark;
        logic [MARK_W-1:0] rx_mark;
    } ufi_cfg_t;

endpackage

// File: rtl/ufi_fifo.sv
module ufi_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             single,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [CW-1:0]    count,
    output logic             empty
);

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
        logic [PW-1:0]               rd;
        logic [PW-1:0]               wr;
        logic [CW-1:0]               cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     full, push_ok, pop_ok;

    always_comb begin
        st_d    = st_q;
        full    = st_q.cnt >= (single ? CW'(1) : CW'(DEPTH));
        empty   = (st_q.cnt == '0);
        push_ok = push && !full && !flush;
        pop_ok  = pop && !empty && !flush;
        if (flush) begin
            st_d.rd  = '0;
            st_d.wr  = '0;
            st_d.cnt = '0;
        end else begin
            if (push_ok) begin
                st_d.mem[st_q.wr] = push_data;
                st_d.wr           = st_q.wr + PW'(1);
            end
            if (pop_ok) begin
                st_d.rd = st_q.rd + PW'(1);
            end
            st_d.cnt = st_q.cnt + CW'(push_ok) - CW'(pop_ok);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head  = st_q.mem[st_q.rd];
    assign count = st_q.cnt;

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH));

    // R3
    full_push_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> (st_q.cnt == $past(st_q.cnt)));

endmodule

// File: rtl/ufi_rx_timeout.sv
module ufi_rx_timeout #(
    parameter int LIMIT = 4,
    localparam int TW = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic char_tick,
    input  logic arrive,
    input  logic pending,
    output logic fire
);

    typedef struct packed {
        logic [TW-1:0] cnt;
    } tmo_st_t;

    tmo_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        fire = 1'b0;
        if (!pending || arrive) begin
            st_d.cnt = '0;
        end else if (char_tick && st_q.cnt != TW'(LIMIT)) begin
            st_d.cnt = st_q.cnt + TW'(1);
            fire     = (st_q.cnt == TW'(LIMIT - 1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R11
    tmo_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= TW'(LIMIT));

    // R11
    tmo_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (st_q.cnt == TW'(LIMIT)));

endmodule

// File: rtl/ufi_irq_status.sv
module ufi_irq_status
    import uart_fifo_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ST_W-1:0] level,
    input  logic [ST_W-1:0] events,
    input  logic            clr_wr,
    input  logic [ST_W-1:0] clr_data,
    input  logic            en_wr,
    input  logic [ST_W-1:0] en_data,
    output logic [ST_W-1:0] status,
    output logic            irq
);

    typedef struct packed {
        logic [ST_W-1:0] latched;
        logic [ST_W-1:0] en;
    } irq_st_t;

    irq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_wr) st_d.latched = st_q.latched & ~clr_data;
        st_d.latched = (st_d.latched | events) & LATCH_MASK;
        if (en_wr)  st_d.en = en_data;
        status = (level & ~LATCH_MASK) | st_q.latched;
        irq    = |(status & st_q.en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R12
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_wr |=> (($past(st_q.latched) & ~st_q.latched) == '0));

    // R13
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.en == '0) |-> !irq);

endmodule

// File: rtl/uart_fifo_irq.sv
module uart_fifo_irq
    import uart_fifo_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int TMO_CHARS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_ctrl_wr,
    input  logic [CTL_W-1:0]  fifo_ctrl_wdata,
    input  logic              irq_en_wr,
    input  logic [ST_W-1:0]   irq_en_wdata,
    input  logic              irq_clr_wr,
    input  logic [ST_W-1:0]   irq_clr_wdata,
    input  logic              tx_wr,
    input  logic [7:0]        tx_wdata,
    input  logic              rx_rd,
    output logic [RXW_W-1:0]  rx_rdata,
    output logic [12:0]       fill_level,
    output logic [ST_W-1:0]   irq_status,
    output logic              irq,
    input  logic              eng_tx_req,
    output logic              eng_tx_valid,
    output logic [7:0]        eng_tx_data,
    input  logic              eng_rx_valid,
    input  logic [RXW_W-1:0]  eng_rx_word,
    input  logic              eng_cts_toggle,
    input  logic              eng_break_done,
    input  logic              eng_char_tick
);

    localparam int CW = $clog2(DEPTH + 1);

    ufi_cfg_t        cfg_d, cfg_q;
    logic            tx_flush, rx_flush;
    logic [CW-1:0]   tx_cnt, rx_cnt;
    logic            tx_empty, rx_empty, rx_full, rx_accept;
    logic [ST_W-1:0] level, events;
    logic            tmo_fire;

    always_comb begin
        cfg_d    = cfg_q;
        tx_flush = fifo_ctrl_wr && fifo_ctrl_wdata[CTL_TXFLUSH];
        rx_flush = fifo_ctrl_wr && fifo_ctrl_wdata[CTL_RXFLUSH];
        if (fifo_ctrl_wr) begin
            cfg_d.q_on    = fifo_ctrl_wdata[CTL_ON];
            cfg_d.tx_mark = fifo_ctrl_wdata[CTL_TXMARK +: MARK_W];
            cfg_d.rx_mark = fifo_ctrl_wdata[CTL_RXMARK +: MARK_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    ufi_fifo #(.WIDTH(8), .DEPTH(DEPTH)) u_tx_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (tx_flush),
        .single    (!cfg_q.q_on),
        .push      (tx_wr),
        .push_data (tx_wdata),
        .pop       (eng_tx_req),
        .head      (eng_tx_data),
        .count     (tx_cnt),
        .empty     (tx_empty)
    );

    ufi_fifo #(.WIDTH(RXW_W), .DEPTH(DEPTH)) u_rx_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (rx_flush),
        .single    (!cfg_q.q_on),
        .push      (eng_rx_valid),
        .push_data (eng_rx_word),
        .pop       (rx_rd),
        .head      (rx_rdata),
        .count     (rx_cnt),
        .empty     (rx_empty)
    );

    ufi_rx_timeout #(.LIMIT(TMO_CHARS)) u_tmo (
        .clk       (clk),
        .rst_n     (rst_n),
        .char_tick (eng_char_tick),
        .arrive    (eng_rx_valid),
        .pending   (!rx_empty),
        .fire      (tmo_fire)
    );

    always_comb begin
        rx_full   = rx_cnt >= (cfg_q.q_on ? CW'(DEPTH) : CW'(1));
        rx_accept = eng_rx_valid && !rx_full && !rx_flush;

        level              = '0;
        level[ST_TXD_MT]   = tx_empty;
        level[ST_RXD_RDY]  = !rx_empty;
        level[ST_TX_LOW]   = cfg_q.q_on && (tx_cnt <= CW'(cfg_q.tx_mark));
        level[ST_TX_MT]    = cfg_q.q_on && tx_empty;
        level[ST_RX_HIGH]  = cfg_q.q_on && (rx_cnt >= CW'(cfg_q.rx_mark));
        level[ST_RX_FULL]  = cfg_q.q_on && (rx_cnt == CW'(DEPTH));

        events              = '0;
        events[ST_TX_UNDER] = eng_tx_req && tx_empty;
        events[ST_RX_OVER]  = eng_rx_valid && rx_full;
        events[ST_PAR_ERR]  = rx_accept && eng_rx_word[RXW_PAR];
        events[ST_FRM_ERR]  = rx_accept && eng_rx_word[RXW_FRM];
        events[ST_CTS_CHG]  = eng_cts_toggle;
        events[ST_RX_TMO]   = tmo_fire;
        events[ST_BRK_END]  = eng_break_done;
    end

    ufi_irq_status u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .level    (level),
        .events   (events),
        .clr_wr   (irq_clr_wr),
        .clr_data (irq_clr_wdata),
        .en_wr    (irq_en_wr),
        .en_data  (irq_en_wdata),
        .status   (irq_status),
        .irq      (irq)
    );

    assign eng_tx_valid = !tx_empty;
    assign fill_level   = {5'(rx_cnt), 3'b000, 5'(tx_cnt)};

    // R7
    overrun_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_rx_valid && rx_full && !rx_flush && !rx_rd)
        |=> (rx_cnt == $past(rx_cnt)) && irq_status[ST_RX_OVER]);

    // R8
    underrun_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_tx_req && tx_empty) |=> irq_status[ST_TX_UNDER]);

    // R2
    ctl_spare_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_ctrl_wr && fifo_ctrl_wdata[1] && !fifo_ctrl_wdata[CTL_TXFLUSH]
         && !eng_tx_req && tx_cnt != '0) |=> (tx_cnt != '0));

    // R13
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_status != '0));

endmodule

// File: tb/uart_fifo_irq_bench.sv
module uart_fifo_irq_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fifo_ctrl_wr = 0;
    logic [11:0] fifo_ctrl_wdata = '0;
    logic        irq_en_wr = 0;
    logic [12:0] irq_en_wdata = '0;
    logic        irq_clr_wr = 0;
    logic [12:0] irq_clr_wdata = '0;
    logic        tx_wr = 0;
    logic [7:0]  tx_wdata = '0;
    logic        rx_rd = 0;
    logic [9:0]  rx_rdata;
    logic [12:0] fill_level;
    logic [12:0] irq_status;
    logic        irq;
    logic        eng_tx_req = 0;
    logic        eng_tx_valid;
    logic [7:0]  eng_tx_data;
    logic        eng_rx_valid = 0;
    logic [9:0]  eng_rx_word = '0;
    logic        eng_cts_toggle = 0;
    logic        eng_break_done = 0;
    logic        eng_char_tick = 0;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    uart_fifo_irq u_uart_fifo_irq (
        .clk             (clk),
        .rst_n           (rst_n),
        .fifo_ctrl_wr    (fifo_ctrl_wr),
        .fifo_ctrl_wdata (fifo_ctrl_wdata),
        .irq_en_wr       (irq_en_wr),
        .irq_en_wdata    (irq_en_wdata),
        .irq_clr_wr      (irq_clr_wr),
        .irq_clr_wdata   (irq_clr_wdata),
        .tx_wr           (tx_wr),
        .tx_wdata        (tx_wdata),
        .rx_rd           (rx_rd),
        .rx_rdata        (rx_rdata),
        .fill_level      (fill_level),
        .irq_status      (irq_status),
        .irq             (irq),
        .eng_tx_req      (eng_tx_req),
        .eng_tx_valid    (eng_tx_valid),
        .eng_tx_data     (eng_tx_data),
        .eng_rx_valid    (eng_rx_valid),
        .eng_rx_word     (eng_rx_word),
        .eng_cts_toggle  (eng_cts_toggle),
        .eng_break_done  (eng_break_done),
        .eng_char_tick   (eng_char_tick)
    );

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_ctrl(input logic on, input int txm, input int rxm,
                           input logic txf, input logic rxf);
        fifo_ctrl_wdata = {4'(rxm), 4'(txm), rxf, txf, 1'b0, on};
        fifo_ctrl_wr = 1; cyc(); fifo_ctrl_wr = 0;
    endtask

    task automatic push_tx(input logic [7:0] b);
        tx_wdata = b; tx_wr = 1; cyc(); tx_wr = 0;
    endtask

    task automatic push_rx(input logic [9:0] w);
        eng_rx_word = w; eng_rx_valid = 1; cyc(); eng_rx_valid = 0;
    endtask

    task automatic clr(input logic [12:0] m);
        irq_clr_wdata = m; irq_clr_wr = 1; cyc(); irq_clr_wr = 0;
    endtask

    task automatic tick();
        eng_char_tick = 1; cyc(); eng_char_tick = 0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        summary();
    end

    initial begin
        repeat (3) cyc();
        rst_n = 1;
        cyc();

        // R1 reset state
        chk("R1 fill", 32'(fill_level), 0);
        chk("R1 status", 32'(irq_status), 32'h001);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 txvalid", 32'(eng_tx_valid), 0);

        // R2 queueing off: capacity one
        push_tx(8'hA5);
        push_tx(8'h3C);
        chk("R2 single fill", 32'(fill_level), 1);
        chk("R3 head", 32'(eng_tx_data), 32'hA5);
        chk("R2 single status", 32'(irq_status), 0);
        eng_tx_req = 1; cyc(); eng_tx_req = 0;
        chk("R3 drained", 32'(fill_level), 0);
        chk("R8 no underrun", 32'(irq_status), 32'h001);

        // R6 transmit low-water sweep, R3 ordering and full drop
        for (int m = 0; m < 16; m++) begin
            wr_ctrl(1, m, 0, 1, 1);
            for (int n = 0; n <= 16; n++) begin
                chk("R6 txcnt", 32'(fill_level[4:0]), 32'(n));
                chk("R6 txlow", 32'(irq_status[2]), 32'(n <= m));
                chk("R6 txmt", 32'(irq_status[3]), 32'(n == 0));
                chk("R6 txd", 32'(irq_status[0]), 32'(n == 0));
                if (n < 16) push_tx(8'(n + 16 * m));
            end
            push_tx(8'hEE);
            chk("R3 full drop", 32'(fill_level[4:0]), 16);
            if (m == 5) begin
                for (int k = 0; k < 16; k++) begin
                    chk("R3 valid", 32'(eng_tx_valid), 1);
                    chk("R3 order", 32'(eng_tx_data), 32'(k + 80));
                    eng_tx_req = 1; cyc(); eng_tx_req = 0;
                end
                chk("R3 empty", 32'(eng_tx_valid), 0);
            end
        end

        // R6 receive high-water sweep, R7 overrun, R4 ordering
        for (int m = 0; m < 16; m++) begin
            wr_ctrl(1, 0, m, 1, 1);
            for (int n = 0; n <= 16; n++) begin
                chk("R6 rxcnt", 32'(fill_level[12:8]), 32'(n));
                chk("R6 rxhigh", 32'(irq_status[4]), 32'(n >= m));
                chk("R6 rxfull", 32'(irq_status[5]), 32'(n == 16));
                chk("R6 rxrdy", 32'(irq_status[1]), 32'(n != 0));
                if (n < 16) push_rx({2'b00, 8'(n * 3 + m)});
            end
            chk("R7 no overrun yet", 32'(irq_status[7]), 0);
            push_rx(10'h0FF);
            chk("R7 count kept", 32'(fill_level[12:8]), 16);
            chk("R7 overrun", 32'(irq_status[7]), 1);
            clr(13'h0080);
            chk("R12 cleared", 32'(irq_status[7]), 0);
            if (m == 7) begin
                for (int k = 0; k < 16; k++) begin
                    chk("R4 order", 32'(rx_rdata), 32'(k * 3 + 7));
                    rx_rd = 1; cyc(); rx_rd = 0;
                end
                chk("R4 drained", 32'(fill_level[12:8]), 0);
            end
        end

        // R5 independent flushes
        wr_ctrl(1, 0, 5, 1, 1);
        push_tx(8'h11); push_tx(8'h22);
        push_rx(10'h001); push_rx(10'h002); push_rx(10'h003);
        wr_ctrl(1, 0, 5, 0, 1);
        chk("R5 rx flush", 32'(fill_level), 32'h0002);
        fifo_ctrl_wdata = 12'h502; fifo_ctrl_wr = 1; cyc(); fifo_ctrl_wr = 0;
        chk("R2 spare bit", 32'(fill_level), 32'h0002);
        wr_ctrl(1, 0, 5, 1, 0);
        chk("R5 tx flush", 32'(fill_level), 0);

        // R8 underrun, R12 clear behaviour
        eng_tx_req = 1; cyc(); eng_tx_req = 0;
        chk("R8 underrun", 32'(irq_status[6]), 1);
        chk("R3 no data", 32'(eng_tx_valid), 0);
        clr(13'h1FFF);
        chk("R12 level kept", 32'(irq_status), 32'h00D);
        eng_cts_toggle = 1; irq_clr_wdata = 13'h0400; irq_clr_wr = 1;
        cyc();
        eng_cts_toggle = 0; irq_clr_wr = 0;
        chk("R12 set wins", 32'(irq_status[10]), 1);
        chk("R10 cts", 32'(irq_status), 32'h40D);
        clr(13'h0400);
        chk("R12 after clear", 32'(irq_status), 32'h00D);

        // R9 error flags
        push_rx(10'h1AB);
        chk("R9 parity", 32'(irq_status[9:8]), 1);
        clr(13'h0100);
        push_rx(10'h2CD);
        chk("R9 frame", 32'(irq_status[9:8]), 2);
        chk("R4 head word", 32'(rx_rdata), 32'h1AB);
        rx_rd = 1; cyc(); rx_rd = 0;
        chk("R4 next word", 32'(rx_rdata), 32'h2CD);
        wr_ctrl(1, 0, 5, 0, 1);
        clr(13'h1FFF);

        // R10 break
        eng_break_done = 1; cyc(); eng_break_done = 0;
        chk("R10 break", 32'(irq_status[12]), 1);
        clr(13'h1000);

        // R11 timeout
        for (int i = 0; i < 6; i++) tick();
        chk("R11 idle empty", 32'(irq_status[11]), 0);
        push_rx(10'h055);
        for (int i = 0; i < 3; i++) tick();
        chk("R11 before", 32'(irq_status[11]), 0);
        tick();
        chk("R11 fired", 32'(irq_status[11]), 1);
        clr(13'h0800);
        push_rx(10'h066);
        for (int i = 0; i < 3; i++) tick();
        chk("R11 restart", 32'(irq_status[11]), 0);
        tick();
        chk("R11 fired again", 32'(irq_status[11]), 1);
        wr_ctrl(1, 0, 5, 0, 1);
        clr(13'h1FFF);

        // R13 per-source masking with status 0x04D
        eng_tx_req = 1; cyc(); eng_tx_req = 0;
        chk("R13 status", 32'(irq_status), 32'h04D);
        for (int i = 0; i < 13; i++) begin
            irq_en_wdata = 13'(1 << i); irq_en_wr = 1; cyc(); irq_en_wr = 0;
            chk("R13 mask", 32'(irq), 32'((32'h04D >> i) & 1));
        end
        irq_en_wdata = '0; irq_en_wr = 1; cyc(); irq_en_wr = 0;
        chk("R13 all off", 32'(irq), 0);

        summary();
    end

endmodule